// File: doc/BRIEF.md
# Cascaded Two-Stage Serial Clock Divider

This block derives a serial bit clock from the system clock using two divider stages in series. The first stage is a prescaler that only accepts even divisors. Bit 0 of its setting is discarded, and the setting is used as the divisor with no offset. The second stage takes a setting equal to its divisor minus one, so every 8-bit value is a legal divisor from 1 to 256. The output frequency is the system clock divided by the product of the two divisors.

Because the first divisor is always even, the combined ratio is even, and the output runs at an exact 50% duty cycle. Each half-period spans `(P/2)*N` system clocks, where P is the effective first divisor and N is the second divisor. Both settings are captured into working registers while the block is disabled and again at the end of every full output period. A change of setting therefore never shortens a pulse.

A one-cycle tick marks every output edge for a neighbouring shift register. When enable is low, the counters are cleared and the output is held low.

Top module: `serclk_cascade_div`

## Requirements
- R1: Once enabled, the output sclk_o changes level every H system clocks, where H = (P/2)*N. The first rise appears after the H-th rising clock edge at which en_i is sampled high.
- R2: Bit 0 of pre_div_i is ignored. The effective first divisor is P = {pre_div_i[7:1],1'b0}, so the odd setting 2k+1 behaves exactly like 2k.
- R3: A first-stage setting of 0 or 1 is treated as P = 2.
- R4: The second-stage setting v (0..255) divides by N = v+1, so v = 255 gives division by 256. The first-stage setting is used directly, with no minus-one offset.
- R5: The output has a 50% duty cycle: it is high for H clocks and low for H clocks in every period.
- R6: tick_o is high for exactly one cycle, in each cycle in which sclk_o first shows a new level while enabled. At all other times it is low.
- R7: New settings written while enabled take effect only after the next falling edge of sclk_o. The period in progress completes with the old settings.
- R8: While en_i is low, sclk_o and tick_o are low and both counters are cleared. Dropping en_i while sclk_o is high forces sclk_o low on the next clock without a tick.
- R9: The active-low asynchronous reset rst_n forces sclk_o and tick_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears the divider and holds the output low |
| pre_div_i | input | 8 | First-stage even divisor (bit 0 ignored; 0 or 1 means 2) |
| post_div_m1_i | input | 8 | Second-stage divisor minus one |
| sclk_o | output | 1 | Divided serial clock, 50% duty |
| tick_o | output | 1 | One-cycle pulse marking each sclk_o edge |

## Verification
On every cycle, the in-module assertions check four things:
- Each tick coincides with an output level change, and each level change made while enabled carries a tick.
- The output and the tick are low after any disabled cycle.
- Neither counter runs past its captured limit.
- The captured settings move only while disabled or at a period end.

The exact half-period length, the effect of bit 0 and of the zero setting, the full 256 range of the second stage, and the deferral of a mid-period change are shown by the bench scenarios. Those scenarios compare every output cycle with a period computed arithmetically from the settings.

// File: rtl/serclk_cascade_div.sv
module serclk_cascade_div #(
  parameter int PRE_W  = 8,
  parameter int POST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  pre_div_i,
  input  logic [POST_W-1:0] post_div_m1_i,
  output logic              sclk_o,
  output logic              tick_o
);
  localparam int HP_W = PRE_W - 1;
  localparam logic [HP_W-1:0]   HP_ONE   = HP_W'(1);
  localparam logic [POST_W-1:0] POST_ONE = POST_W'(1);

  logic [HP_W-1:0]   hp_q, c1_q;
  logic [POST_W-1:0] nm1_q, c2_q;
  logic              sclk_q, tick_q;

  wire [HP_W-1:0] pre_half = pre_div_i[PRE_W-1:1];
  wire [HP_W-1:0] hp_next  = (pre_half == '0) ? HP_ONE : pre_half;
  wire            s1       = (c1_q == hp_q - HP_ONE);
  wire            flip     = s1 && (c2_q == nm1_q);
  wire            reload   = !en_i || (flip && sclk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q   <= HP_ONE;
      nm1_q  <= '0;
      c1_q   <= '0;
      c2_q   <= '0;
      sclk_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= en_i && flip;
      if (reload) begin
        hp_q  <= hp_next;
        nm1_q <= post_div_m1_i;
      end
      if (!en_i) begin
        c1_q   <= '0;
        c2_q   <= '0;
        sclk_q <= 1'b0;
      end else begin
        c1_q <= s1 ? '0 : c1_q + HP_ONE;
        if (flip) begin
          c2_q   <= '0;
          sclk_q <= ~sclk_q;
        end else if (s1) begin
          c2_q <= c2_q + POST_ONE;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign tick_o = tick_q;

  // R6: a tick always accompanies a level change, and vice versa while running
  a_r6_tick_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (sclk_o != $past(sclk_o)));
  a_r6_edge_has_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && (sclk_o != $past(sclk_o))) |-> tick_o);

  // R8: disabled means quiet output on the next cycle
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sclk_o && !tick_o));

  // R1: counters stay inside the captured limits
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_q < hp_q) && (c2_q <= nm1_q));

  // R7: captured settings change only when idle or at a period end
  a_r7_hold_settings: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && !(tick_o && !sclk_o)) |-> ($stable(hp_q) && $stable(nm1_q)));
endmodule

// File: tb/serclk_cascade_div_tb_top.sv
module serclk_cascade_div_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] pre_v = 8'd2;
  logic [7:0] post_v = 8'd0;
  logic sclk, tick;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  serclk_cascade_div dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .pre_div_i(pre_v), .post_div_m1_i(post_v),
    .sclk_o(sclk), .tick_o(tick)
  );

  function automatic int half_len(input int pre, input int post);
    int p;
    p = pre - (pre % 2);
    if (p == 0) p = 2;
    return (p / 2) * (post + 1);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_cfg(input int pre, input int post, input int periods, input string req);
    int h;
    idle(2);
    pre_v = 8'(pre);
    post_v = 8'(post);
    @(negedge clk);
    en = 1'b1;
    h = half_len(pre, post);
    for (int k = 1; k <= 2 * h * periods; k++) begin
      @(negedge clk);
      check({req, " sclk"}, int'(sclk), (k / h) % 2);
      check({req, " tick"}, int'(tick), (k % h == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    #5;
    check("R9 reset sclk", int'(sclk), 0);
    check("R9 reset tick", int'(tick), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle sclk", int'(sclk), 0);

    // R1 R5 R6 sweep; odd settings exercise R2, 0 and 1 exercise R3
    for (int p = 0; p < 10; p++)
      for (int q = 0; q < 6; q++)
        run_cfg(p, q, 2, (p < 2) ? "R3" : ((p % 2) ? "R2" : "R1 R5 R6"));

    // R4: full range of both stages
    run_cfg(2, 255, 1, "R4 post 256");
    run_cfg(255, 0, 1, "R4 R2 pre 254");
    run_cfg(254, 1, 1, "R4 pre 254 post 2");

    // R7: change mid-period, old period (H=6) finishes first, then H=1
    idle(2);
    pre_v = 8'd4;
    post_v = 8'd2;
    @(negedge clk);
    en = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      if (k == 3) begin
        pre_v = 8'd2;
        post_v = 8'd0;
      end
      if (k <= 12) begin
        check("R7 old sclk", int'(sclk), (k / 6) % 2);
        check("R7 old tick", int'(tick), (k % 6 == 0) ? 1 : 0);
      end else begin
        check("R7 new sclk", int'(sclk), (k - 12) % 2);
        check("R7 new tick", int'(tick), 1);
      end
    end

    // R8: dropping enable while high forces low without tick
    idle(2);
    pre_v = 8'd2;
    post_v = 8'd3;
    @(negedge clk);
    en = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 high before drop", int'(sclk), 1);
    en = 1'b0;
    @(negedge clk);
    check("R8 drop sclk", int'(sclk), 0);
    check("R8 drop tick", int'(tick), 0);
    repeat (10) @(negedge clk);
    check("R8 held sclk", int'(sclk), 0);
    check("R8 held tick", int'(tick), 0);

    // R9: asynchronous reset while running high
    en = 1'b1;
    repeat (5) @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    check("R9 async sclk", int'(sclk), 0);
    check("R9 async tick", int'(tick), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule